// File: doc/BRIEF.md
# NAND Page Hamming Code Accumulator

This block sits beside the byte-wide data path of a NAND flash controller. While it is told to accumulate, every byte that crosses the path is folded into a Hamming code for the 256-byte chunk that byte belongs to. Each chunk yields three code bytes, which is enough for host software to repair any single flipped bit in the chunk and to notice a double-bit fault. One engine covers a 512-byte page as two chunks, so a page carries six code bytes.

A two-bit mode input steers the engine. It can be off, accumulating, reading out, or clearing. To start a page, the host clears the engine, then sets it off, then sets it to accumulate. To fetch the codes, the host sets it off, then to readout, then off again. While in readout, the read-data output no longer carries flash data. Instead, each read strobe steps through the stored code bytes in a fixed order. The block only computes and delivers the code. Correction itself is done by software.

Top module: `nand_ecc_accum`

## Requirements
- R1: `ecc_mode` is decoded as follows: 2'b00 is off, 2'b01 accumulates, 2'b10 reads out and 2'b11 clears. In off mode, bytes with `data_valid` high leave every stored code unchanged.
- R2: Clear mode zeroes both chunk codes and the byte counter. After a clear, and after reset, every code byte reads back as 8'hFF.
- R3: Each code byte is the bitwise inverse of its parity bits.
  - For address bit i (i = 0..3), code byte 0 holds the even line parity in bit 2i and the odd line parity in bit 2i+1. Code byte 1 does the same for i = 4..7 in bits 2(i-4) and 2(i-4)+1.
  - The even line parity of address bit i is the XOR of all data bits in the bytes whose in-chunk address has bit i clear. The odd line parity uses the bytes whose address has bit i set.
  - Code byte 2 holds the column parities. Bit 2+2j is the XOR of data bits whose bit index has bit j clear, and bit 3+2j uses the bits whose index has bit j set, for j = 0..2. Bits [1:0] of code byte 2 are always 1.
  - Example: a single byte 8'h01 at address 0 gives code bytes 0, 1 and 2 equal to 8'hAA, 8'hAA and 8'hAB.
- R4: Each byte with `data_valid` high in accumulate mode updates the current chunk's code. Bytes 0 to 255 after a clear go to chunk 0, and bytes 256 to 511 go to chunk 1.
- R5: After 512 bytes the counter wraps. Further bytes are folded into chunk 0 again, starting at address 0, on top of its existing code.
- R6: In readout mode each read returns the next code byte in this order: chunk 0 byte 1, byte 0, byte 2, then chunk 1 byte 1, byte 0, byte 2. The order then repeats from chunk 0 byte 1.
- R7: When `ecc_mode` changes into readout from any other mode, the readout pointer returns to the first position. This holds even after a partial readout.
- R8: When not in readout mode, `rd_data` equals `flash_rdata`. In readout mode, `data_valid` does not alter any stored code.
- R9: Reading the codes does not change them, so a second full readout returns the same six bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ecc_mode | input | 2 | Engine mode: off, accumulate, readout or clear |
| data_valid | input | 1 | A byte crosses the flash data path this cycle |
| data_byte | input | 8 | The byte crossing the data path |
| rd_strobe | input | 1 | Host reads the data register this cycle |
| flash_rdata | input | 8 | Read data coming from the flash side |
| rd_data | output | 8 | Data register read value: flash data, or a code byte in readout |

## Verification
The hardest state to reach from the ports is the counter wrap after 512 bytes. There the third group of bytes must fold into chunk 0 on top of the first group, while chunk 1 must stay exactly as the second group left it. The bench drives 517 bytes from a computed pattern. Its reference model XORs each byte into a per-address image, so the expected chunk 0 code includes both passes.

A second hard case is re-entering readout after a partial readout. To reach it, the bench drops out of readout mid-sequence and returns, checking that the first byte is chunk 0 byte 1 again.

// File: rtl/nand_ecc_pkg.sv
// Shared types for the NAND Hamming code accumulator.
// Assumes the two-bit mode encoding is fixed by the host driver.
package nand_ecc_pkg;
    typedef enum logic [1:0] {
        ECC_OFF   = 2'b00,
        ECC_ACCUM = 2'b01,
        ECC_READ  = 2'b10,
        ECC_CLEAR = 2'b11
    } ecc_mode_e;

    localparam int CODE_BYTES   = 3;
    localparam int CODE_W       = 8 * CODE_BYTES;
    localparam int SLOT_W       = 2;
endpackage

// File: rtl/nand_ecc_chunk.sv
// Parity accumulator for one chunk.
// Folds each enabled byte into line and column parities and presents the
// three inverted code bytes as {byte2, byte1, byte0}.
// Assumes ADDR_W = 8, which makes 16 line parities fill code bytes 0 and 1.
module nand_ecc_chunk
    import nand_ecc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic [CODE_W-1:0] code_o
);
    logic [ADDR_W-1:0]   lp_even, lp_odd;
    logic [2:0]          cp_even, cp_odd;
    logic [2:0]          col_e, col_o;
    logic                row_par;
    logic [2*ADDR_W-1:0] lp_pair;

    // Column parity contributions and row parity of the incoming byte.
    always_comb begin
        row_par = ^data_i;
        for (int j = 0; j < 3; j++) begin
            col_e[j] = 1'b0;
            col_o[j] = 1'b0;
            for (int b = 0; b < 8; b++) begin
                if (((b >> j) & 1) != 0) col_o[j] = col_o[j] ^ data_i[b];
                else                     col_e[j] = col_e[j] ^ data_i[b];
            end
        end
    end

    // Parity state update: clear wins over accumulate.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            lp_even <= '0;
            lp_odd  <= '0;
            cp_even <= '0;
            cp_odd  <= '0;
        end else if (en_i) begin
            lp_odd  <= lp_odd  ^ ({ADDR_W{row_par}} &  addr_i);
            lp_even <= lp_even ^ ({ADDR_W{row_par}} & ~addr_i);
            cp_odd  <= cp_odd  ^ col_o;
            cp_even <= cp_even ^ col_e;
        end
    end

    // Interleave even/odd line parities into byte order.
    for (genvar i = 0; i < ADDR_W; i++) begin : g_pair
        assign lp_pair[2*i]   = ~lp_even[i];
        assign lp_pair[2*i+1] = ~lp_odd[i];
    end

    assign code_o = {~cp_odd[2], ~cp_even[2], ~cp_odd[1], ~cp_even[1],
                     ~cp_odd[0], ~cp_even[0], 2'b11,
                     lp_pair[15:8], lp_pair[7:0]};

    AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (code_o == '1)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clear_i) |=> $stable(code_o)); // R1
endmodule

// File: rtl/nand_ecc_seq.sv
// Mode sequencer for the accumulator.
// Keeps the byte address and chunk index for accumulation, and the readout
// pointer (chunk, slot) used to pick code bytes. The pointer restarts when
// readout mode is entered.
module nand_ecc_seq
    import nand_ecc_pkg::*;
#(
    parameter int CHUNKS      = 2,
    parameter int CHUNK_BYTES = 256,
    localparam int ADDR_W     = $clog2(CHUNK_BYTES),
    localparam int CIDX_W     = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ecc_mode_e         mode_i,
    input  logic              data_valid_i,
    input  logic              rd_strobe_i,
    output logic [ADDR_W-1:0] byte_addr_o,
    output logic [CIDX_W-1:0] chunk_idx_o,
    output logic              acc_en_o,
    output logic              clear_o,
    output logic              rd_active_o,
    output logic [CIDX_W-1:0] rd_chunk_o,
    output logic [SLOT_W-1:0] rd_slot_o
);
    logic [ADDR_W-1:0] addr_q;
    logic [CIDX_W-1:0] chunk_q, rd_chunk_q, eff_chunk;
    logic [SLOT_W-1:0] rd_slot_q, eff_slot;
    ecc_mode_e         prev_mode;
    logic              entering;

    assign acc_en_o    = (mode_i == ECC_ACCUM) && data_valid_i;
    assign clear_o     = (mode_i == ECC_CLEAR);
    assign rd_active_o = (mode_i == ECC_READ);
    assign entering    = rd_active_o && (prev_mode != ECC_READ);

    // Byte address and chunk index of the next accumulated byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_o) begin
            addr_q  <= '0;
            chunk_q <= '0;
        end else if (acc_en_o) begin
            addr_q <= addr_q + 1'b1;
            if (addr_q == ADDR_W'(CHUNK_BYTES - 1))
                chunk_q <= (chunk_q == CIDX_W'(CHUNKS - 1)) ? '0 : chunk_q + 1'b1;
        end
    end

    // Remember the previous mode to detect entry into readout.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_mode <= ECC_OFF;
        else        prev_mode <= mode_i;
    end

    // Effective pointer: first position on the cycle readout is entered.
    always_comb begin
        eff_chunk = entering ? '0 : rd_chunk_q;
        eff_slot  = entering ? '0 : rd_slot_q;
    end

    // Readout pointer: steps slot 0..2, then moves to the next chunk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_chunk_q <= '0;
            rd_slot_q  <= '0;
        end else if (rd_active_o) begin
            if (rd_strobe_i) begin
                if (eff_slot == SLOT_W'(CODE_BYTES - 1)) begin
                    rd_slot_q  <= '0;
                    rd_chunk_q <= (eff_chunk == CIDX_W'(CHUNKS - 1)) ? '0 : eff_chunk + 1'b1;
                end else begin
                    rd_slot_q  <= eff_slot + 1'b1;
                    rd_chunk_q <= eff_chunk;
                end
            end else begin
                rd_slot_q  <= eff_slot;
                rd_chunk_q <= eff_chunk;
            end
        end
    end

    assign byte_addr_o = addr_q;
    assign chunk_idx_o = chunk_q;
    assign rd_chunk_o  = eff_chunk;
    assign rd_slot_o   = eff_slot;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_o && addr_q != '1) |=> (addr_q == $past(addr_q) + 1'b1)); // R4
    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_o && addr_q == '1) |=> (addr_q == '0)); // R5
    AST_CLEAR_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (addr_q == '0 && chunk_q == '0)); // R2
    AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_active_o && rd_strobe_i && rd_slot_o == SLOT_W'(CODE_BYTES - 1)
         && rd_chunk_o == CIDX_W'(CHUNKS - 1))
        |=> (!rd_active_o || (rd_chunk_o == '0 && rd_slot_o == '0))); // R6
    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_slot_q < SLOT_W'(CODE_BYTES)); // R6
endmodule

// File: rtl/nand_ecc_accum.sv
// Top of the NAND Hamming code accumulator.
// One parity accumulator per chunk, a shared sequencer, and a read mux that
// swaps flash data for code bytes while in readout mode.
// Assumes 256-byte chunks (three code bytes each).
module nand_ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int CHUNKS      = 2,
    parameter int CHUNK_BYTES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ecc_mode,
    input  logic       data_valid,
    input  logic [7:0] data_byte,
    input  logic       rd_strobe,
    input  logic [7:0] flash_rdata,
    output logic [7:0] rd_data
);
    localparam int ADDR_W = $clog2(CHUNK_BYTES);
    localparam int CIDX_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;

    logic [ADDR_W-1:0] byte_addr;
    logic [CIDX_W-1:0] chunk_idx, rd_chunk;
    logic [SLOT_W-1:0] rd_slot;
    logic              acc_en, clear, rd_active;
    logic [CODE_W-1:0] codes [CHUNKS];
    logic [CODE_W-1:0] sel_code;
    logic [7:0]        code_byte;

    nand_ecc_seq #(.CHUNKS(CHUNKS), .CHUNK_BYTES(CHUNK_BYTES)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (ecc_mode_e'(ecc_mode)),
        .data_valid_i (data_valid),
        .rd_strobe_i  (rd_strobe),
        .byte_addr_o  (byte_addr),
        .chunk_idx_o  (chunk_idx),
        .acc_en_o     (acc_en),
        .clear_o      (clear),
        .rd_active_o  (rd_active),
        .rd_chunk_o   (rd_chunk),
        .rd_slot_o    (rd_slot)
    );

    for (genvar g = 0; g < CHUNKS; g++) begin : g_chunk
        nand_ecc_chunk #(.ADDR_W(ADDR_W)) u_chunk (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear),
            .en_i    (acc_en && (chunk_idx == CIDX_W'(g))),
            .addr_i  (byte_addr),
            .data_i  (data_byte),
            .code_o  (codes[g])
        );
    end

    // Pick the code byte for the current slot: byte 1, byte 0, byte 2.
    always_comb begin
        sel_code = codes[rd_chunk];
        case (rd_slot)
            2'd0:    code_byte = sel_code[15:8];
            2'd1:    code_byte = sel_code[7:0];
            default: code_byte = sel_code[23:16];
        endcase
    end

    assign rd_data = rd_active ? code_byte : flash_rdata;
endmodule

// File: tb/tb_nand_ecc_accum.sv
module tb_nand_ecc_accum;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] ecc_mode;
    logic       data_valid;
    logic [7:0] data_byte;
    logic       rd_strobe;
    logic [7:0] flash_rdata;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [7:0] mdl [2][256];
    int         mcount;

    nand_ecc_accum dut (
        .clk(clk), .rst_n(rst_n), .ecc_mode(ecc_mode), .data_valid(data_valid),
        .data_byte(data_byte), .rd_strobe(rd_strobe), .flash_rdata(flash_rdata),
        .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Reference code for a chunk, built from the R3 definition.
    function automatic logic [23:0] ref_code(input int c);
        logic [7:0] le, lo;
        logic [2:0] ce, co;
        logic [7:0] b0, b1, b2;
        le = '0; lo = '0; ce = '0; co = '0;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 8; b++) begin
                logic bit_v;
                bit_v = mdl[c][a][b];
                for (int i = 0; i < 8; i++) begin
                    if (((a >> i) & 1) != 0) lo[i] = lo[i] ^ bit_v;
                    else                     le[i] = le[i] ^ bit_v;
                end
                for (int j = 0; j < 3; j++) begin
                    if (((b >> j) & 1) != 0) co[j] = co[j] ^ bit_v;
                    else                     ce[j] = ce[j] ^ bit_v;
                end
            end
        end
        for (int i = 0; i < 4; i++) begin
            b0[2*i] = ~le[i];   b0[2*i+1] = ~lo[i];
            b1[2*i] = ~le[i+4]; b1[2*i+1] = ~lo[i+4];
        end
        b2 = {~co[2], ~ce[2], ~co[1], ~ce[1], ~co[0], ~ce[0], 2'b11};
        return {b2, b1, b0};
    endfunction

    function automatic logic [7:0] ref_read(input int k);
        logic [23:0] c;
        c = ref_code((k % 6) / 3);
        case (k % 3)
            0:       return c[15:8];
            1:       return c[7:0];
            default: return c[23:16];
        endcase
    endfunction

    task automatic model_clear();
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 256; a++) mdl[c][a] = 8'h00;
        mcount = 0;
    endtask

    task automatic hw_clear();
        @(negedge clk);
        ecc_mode = 2'b11;
        @(negedge clk);
        ecc_mode = 2'b00;
        @(negedge clk);
        model_clear();
    endtask

    task automatic send_byte(input logic [7:0] d, input logic [1:0] mode, input bit track);
        ecc_mode   = mode;
        data_valid = 1'b1;
        data_byte  = d;
        @(negedge clk);
        data_valid = 1'b0;
        if (track) begin
            mdl[mcount / 256][mcount % 256] ^= d;
            mcount = (mcount + 1) % 512;
        end
    endtask

    // Full readout of n bytes starting on readout entry.
    task automatic readout(input string req, input int n);
        ecc_mode  = 2'b10;
        rd_strobe = 1'b1;
        for (int k = 0; k < n; k++) begin
            #1;
            check8(req, rd_data, ref_read(k));
            @(negedge clk);
        end
        rd_strobe = 1'b0;
        ecc_mode  = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        #1;
        flash_rdata = 8'h3C;
        #1;
        check8("R8 passthrough after reset", rd_data, 8'h3C);
        model_clear();
        readout("R2 reset codes all FF", 6);
    endtask

    task automatic t_passthru();
        ecc_mode = 2'b01; flash_rdata = 8'hA5; #1;
        check8("R8 passthrough accumulate", rd_data, 8'hA5);
        ecc_mode = 2'b11; flash_rdata = 8'h5A; #1;
        check8("R8 passthrough clear", rd_data, 8'h5A);
        @(negedge clk);
        ecc_mode = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_single();
        hw_clear();
        send_byte(8'h01, 2'b01, 1);
        ecc_mode = 2'b00;
        @(negedge clk);
        ecc_mode = 2'b10; rd_strobe = 1'b1;
        #1 check8("R3 single byte code byte1", rd_data, 8'hAA);
        @(negedge clk); #1 check8("R3 single byte code byte0", rd_data, 8'hAA);
        @(negedge clk); #1 check8("R3 single byte code byte2", rd_data, 8'hAB);
        @(negedge clk); #1 check8("R4 chunk1 untouched", rd_data, 8'hFF);
        @(negedge clk);
        rd_strobe = 1'b0; ecc_mode = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_full_page();
        hw_clear();
        for (int i = 0; i < 512; i++)
            send_byte(8'((i * 37) ^ (i >> 3) ^ 8'h5B), 2'b01, 1);
        ecc_mode = 2'b00;
        @(negedge clk);
        readout("R4 R6 full page codes", 6);
        readout("R9 second readout unchanged", 6);
        readout("R6 pointer wraps to chunk 0", 8);
    endtask

    task automatic t_ignored();
        for (int i = 0; i < 20; i++) send_byte(8'(i * 11 + 1), 2'b00, 0);
        ecc_mode = 2'b00;
        readout("R1 off-mode bytes ignored", 6);
        ecc_mode = 2'b10; rd_strobe = 1'b0;
        for (int i = 0; i < 10; i++) send_byte(8'(i + 7), 2'b10, 0);
        ecc_mode = 2'b00;
        @(negedge clk);
        readout("R8 readout-mode bytes ignored", 6);
    endtask

    task automatic t_reentry();
        ecc_mode = 2'b10; rd_strobe = 1'b1;
        #1 check8("R7 partial read first", rd_data, ref_read(0));
        @(negedge clk); #1 check8("R7 partial read second", rd_data, ref_read(1));
        @(negedge clk); #1 check8("R7 partial read third", rd_data, ref_read(2));
        @(negedge clk);
        ecc_mode = 2'b00; rd_strobe = 1'b0;
        @(negedge clk);
        readout("R7 re-entry restarts at chunk0 byte1", 3);
    endtask

    task automatic t_wrap();
        hw_clear();
        for (int i = 0; i < 517; i++)
            send_byte(8'((i * 13) ^ 8'hC3 ^ (i >> 5)), 2'b01, 1);
        ecc_mode = 2'b00;
        @(negedge clk);
        readout("R5 wrap folds into chunk 0", 6);
    endtask

    task automatic t_clear_after_data();
        @(negedge clk);
        ecc_mode = 2'b11;
        @(negedge clk);
        ecc_mode = 2'b00;
        model_clear();
        @(negedge clk);
        readout("R2 clear after data gives FF", 6);
        send_byte(8'h80, 2'b01, 1);
        ecc_mode = 2'b00;
        @(negedge clk);
        readout("R2 counter cleared R3 first addr", 6);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ecc_mode = 2'b00; data_valid = 1'b0; data_byte = 8'h00;
        rd_strobe = 1'b0; flash_rdata = 8'h00;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_passthru();
        t_single();
        t_full_page();
        t_ignored();
        t_reentry();
        t_wrap();
        t_clear_after_data();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule